// File: doc/BRIEF.md
# Operand Address Sequencer

This block turns one operand specifier into an operand value for a general-register processor. A request carries a 4-bit addressing-mode code, a 2-bit operand-size code, a base register value, an index register value and a constant. The constant serves as an offset, an absolute address or an immediate value, depending on the mode. The block forms the effective address and reads a synchronous memory. Such a memory presents data one cycle after a read is issued. For the memory-indirect mode it chains two reads. The result goes out with an illegal-mode flag. For the post-increment and pre-decrement modes it also emits a one-cycle write-back of the updated base register. The register file and any arithmetic on the operand belong to the surrounding pipeline.

Requests and responses are both valid/ready streams. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the response has been taken, so at most one operation is in flight. A response stays on the port, with `rsp_data` and `rsp_illegal` unchanged, for as long as `rsp_ready` is low. It is removed on the first rising edge where `rsp_valid` and `rsp_ready` are both high, and `req_ready` rises on that same edge. The memory read port has no back-pressure. The block expects read data on `rd_data` during the cycle after it raised `rd_en`.

Top module: `opnd_addr_unit`

## Requirements
- R1: Asynchronous active-low reset puts the block idle: `req_ready`=1, `rsp_valid`=0, `rd_en`=0 and `wb_en`=0. This holds also when reset arrives in the middle of an operation.
- R2: Requests and responses follow the handshake rules above.
  - `req_ready` is 0 in the cycle after a request is accepted.
  - While `rsp_valid`=1 and `rsp_ready`=0, the response port holds `rsp_valid`=1 and keeps `rsp_data` and `rsp_illegal` stable.
  - After the response is taken, `rsp_valid`=0 and `req_ready`=1.
- R3: Mode 0 (register) returns the base value and mode 1 (immediate) returns the constant.
  - Neither mode reads memory.
  - `rsp_valid` is high right after the accepting edge.
- R4: The single-read modes each issue exactly one read and return the data read at that address:
  - mode 2 reads at constant+base;
  - mode 3 reads at base;
  - mode 4 reads at base+index;
  - mode 5 reads at the constant.
  - All address sums wrap modulo 2^W.
  - `rsp_valid` is high after the second rising edge following the accepting edge.
- R5: Mode 6 (memory-indirect) reads at base first. In the next cycle it reads at the full word just returned, and it returns the data of that second read. `rsp_valid` is high after the third rising edge following the accepting edge.
- R6: Mode 7 (post-increment) reads at the old base and returns that data. It drives `wb_data`=base+d, and `wb_en` is high in the cycle after the read.
- R7: Mode 8 (pre-decrement) drives `wb_data`=base−d with `wb_en` high in the same cycle as its read. That read is at base−d.
- R8: Mode 9 (scaled) reads at constant+base+index×d and returns that data.
- R9: The size code s (bits 1:0 of `req_size`) selects d = 2^s, that is 1, 2, 4 or 8.
- R10: Mode codes 10 to 15 are illegal.
  - The response carries `rsp_illegal`=1 and `rsp_data`=0, high right after the accepting edge.
  - The operation makes no memory read and no write-back.
  - Legal modes answer with `rsp_illegal`=0.
- R11: `wb_en` is high for exactly one cycle per operation in modes 7 and 8, and is never high in any other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_mode | input | 4 | Addressing-mode code (0..9 legal) |
| req_size | input | 2 | Operand size code, d = 2^code bytes |
| req_base | input | W | Base register value |
| req_index | input | W | Index register value |
| req_const | input | W | Offset, absolute address or immediate |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | W | Memory read address |
| rd_data | input | W | Memory read data, valid the cycle after `rd_en` |
| wb_en | output | 1 | Base register write-back strobe |
| wb_data | output | W | Updated base register value |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | W | Operand value |
| rsp_illegal | output | 1 | Request carried an undefined mode code |

## Verification
The in-line properties check several behaviours on every cycle:
- the response holds steady under back-pressure;
- `req_ready` drops after an acceptance;
- the write-back strobe lasts one cycle and appears only in the two auto-modify modes;
- a pre-decrement write-back coincides with a read at the written value;
- an illegal request stays off both the read port and the write-back port.

Only the bench's scenarios can show that each mode returns the right data from the right addresses. They also show the order and spacing of the two chained reads and the response latency of each mode class. The remaining scenario-only points are address wrap-around, the effect of each size code, and recovery from a reset that lands in the middle of an operation.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

  localparam int MODE_W = 4;
  localparam int SIZE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    AM_REG    = 4'd0,
    AM_IMM    = 4'd1,
    AM_DISP   = 4'd2,
    AM_RIND   = 4'd3,
    AM_INDEX  = 4'd4,
    AM_ABS    = 4'd5,
    AM_MIND   = 4'd6,
    AM_AINC   = 4'd7,
    AM_ADEC   = 4'd8,
    AM_SCALED = 4'd9
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_CAPT,
    ST_CAPT2,
    ST_RESP
  } ostate_e;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return m <= AM_SCALED;
  endfunction

endpackage

// File: rtl/idx_scaler.sv
module idx_scaler #(
  parameter int W      = 32,
  parameter int SIZE_W = 2
) (
  input  logic [W-1:0]      idx,
  input  logic [SIZE_W-1:0] sz,
  output logic [W-1:0]      scaled
);
  localparam int NSZ = 1 << SIZE_W;

  logic [W-1:0] shifted [NSZ];

  generate
    for (genvar k = 0; k < NSZ; k++) begin : g_sh
      assign shifted[k] = idx << k;
    end
  endgenerate

  assign scaled = shifted[sz];
endmodule

// File: rtl/ea_sum.sv
module ea_sum
  import opnd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [SIZE_W-1:0] sz,
  input  logic [W-1:0]      base,
  input  logic [W-1:0]      idx,
  input  logic [W-1:0]      cst,
  input  logic [W-1:0]      scaled,
  output logic [W-1:0]      ea,
  output logic [W-1:0]      wb_val
);
  logic [W-1:0] step;

  assign step = W'(1) << sz;

  always_comb begin
    case (mode)
      AM_DISP:   ea = cst + base;
      AM_INDEX:  ea = base + idx;
      AM_ABS:    ea = cst;
      AM_ADEC:   ea = base - step;
      AM_SCALED: ea = cst + base + scaled;
      default:   ea = base;
    endcase
  end

  assign wb_val = (mode == AM_ADEC) ? (base - step) : (base + step);
endmodule

// File: rtl/opnd_ctrl.sv
module opnd_ctrl
  import opnd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [W-1:0]      req_base,
  input  logic [W-1:0]      req_index,
  input  logic [W-1:0]      req_const,
  output logic [MODE_W-1:0] mode_q,
  output logic [SIZE_W-1:0] sz_q,
  output logic [W-1:0]      base_q,
  output logic [W-1:0]      idx_q,
  output logic [W-1:0]      cst_q,
  input  logic [W-1:0]      ea,
  input  logic [W-1:0]      wb_val,
  output logic              rd_en,
  output logic [W-1:0]      rd_addr,
  input  logic [W-1:0]      rd_data,
  output logic              wb_en,
  output logic [W-1:0]      wb_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [W-1:0]      rsp_data,
  output logic              rsp_illegal
);
  ostate_e      state;
  logic [W-1:0] res_q;
  logic         ill_q;
  logic         is_mind;

  assign is_mind = (mode_q == AM_MIND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= '0;
      sz_q   <= '0;
      base_q <= '0;
      idx_q  <= '0;
      cst_q  <= '0;
      res_q  <= '0;
      ill_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            mode_q <= req_mode;
            sz_q   <= req_size;
            base_q <= req_base;
            idx_q  <= req_index;
            cst_q  <= req_const;
            ill_q  <= !mode_legal(req_mode);
            if (!mode_legal(req_mode)) begin
              res_q <= '0;
              state <= ST_RESP;
            end else if (req_mode == AM_REG) begin
              res_q <= req_base;
              state <= ST_RESP;
            end else if (req_mode == AM_IMM) begin
              res_q <= req_const;
              state <= ST_RESP;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: state <= ST_CAPT;
        ST_CAPT: begin
          if (is_mind) begin
            state <= ST_CAPT2;
          end else begin
            res_q <= rd_data;
            state <= ST_RESP;
          end
        end
        ST_CAPT2: begin
          res_q <= rd_data;
          state <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // The pointer returned by the first indirect read feeds the address port directly.
  assign req_ready   = (state == ST_IDLE);
  assign rd_en       = (state == ST_ISSUE) || (state == ST_CAPT && is_mind);
  assign rd_addr     = (state == ST_CAPT) ? rd_data : ea;
  assign wb_en       = (state == ST_ISSUE && mode_q == AM_ADEC) ||
                       (state == ST_CAPT  && mode_q == AM_AINC);
  assign wb_data     = wb_val;
  assign rsp_valid   = (state == ST_RESP);
  assign rsp_data    = res_q;
  assign rsp_illegal = ill_q;

  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_illegal)));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R11
  wb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !wb_en);

  // R11
  wb_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (mode_q == AM_AINC || mode_q == AM_ADEC));

  // R7
  adec_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && mode_q == AM_ADEC) |-> (rd_en && rd_addr == wb_data));

  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ill_q && state != ST_IDLE) |-> (!rd_en && !wb_en));

endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import opnd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [3:0]   req_mode,
  input  logic [1:0]   req_size,
  input  logic [W-1:0] req_base,
  input  logic [W-1:0] req_index,
  input  logic [W-1:0] req_const,
  output logic         rd_en,
  output logic [W-1:0] rd_addr,
  input  logic [W-1:0] rd_data,
  output logic         wb_en,
  output logic [W-1:0] wb_data,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data,
  output logic         rsp_illegal
);
  logic [MODE_W-1:0] mode_q;
  logic [SIZE_W-1:0] sz_q;
  logic [W-1:0]      base_q;
  logic [W-1:0]      idx_q;
  logic [W-1:0]      cst_q;
  logic [W-1:0]      scaled;
  logic [W-1:0]      ea;
  logic [W-1:0]      wb_val;

  idx_scaler #(.W(W), .SIZE_W(SIZE_W)) u_scale (
    .idx    (idx_q),
    .sz     (sz_q),
    .scaled (scaled)
  );

  ea_sum #(.W(W)) u_sum (
    .mode   (mode_q),
    .sz     (sz_q),
    .base   (base_q),
    .idx    (idx_q),
    .cst    (cst_q),
    .scaled (scaled),
    .ea     (ea),
    .wb_val (wb_val)
  );

  opnd_ctrl #(.W(W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_mode    (req_mode),
    .req_size    (req_size),
    .req_base    (req_base),
    .req_index   (req_index),
    .req_const   (req_const),
    .mode_q      (mode_q),
    .sz_q        (sz_q),
    .base_q      (base_q),
    .idx_q       (idx_q),
    .cst_q       (cst_q),
    .ea          (ea),
    .wb_val      (wb_val),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .wb_en       (wb_en),
    .wb_data     (wb_data),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_data    (rsp_data),
    .rsp_illegal (rsp_illegal)
  );
endmodule

// File: tb/opnd_addr_unit_tb_top.sv
`timescale 1ns/1ps
module opnd_addr_unit_tb_top;
  localparam int W  = 32;
  localparam int NV = 14;

  // Mode codes: 0 reg, 1 imm, 2 disp, 3 reg-indirect, 4 indexed, 5 absolute,
  // 6 memory-indirect, 7 post-increment, 8 pre-decrement, 9 scaled, 10..15 illegal.
  localparam logic [3:0] V_MODE [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6,
                                         4'd7, 4'd8, 4'd9, 4'd9, 4'd12, 4'd15, 4'd7};
  localparam logic [1:0] V_SIZE [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0,
                                         2'd2, 2'd3, 2'd1, 2'd3, 2'd0, 2'd2, 2'd0};
  localparam logic [W-1:0] V_BASE [NV] = '{32'h1234_5678, 32'h0000_0011, 32'h0000_0020,
      32'h0000_0300, 32'h0000_0100, 32'h0000_0777, 32'h0000_0050, 32'h0000_1000,
      32'h0000_0004, 32'h0000_0200, 32'h0000_0000, 32'h0000_0005, 32'h0000_0009,
      32'hFFFF_FFFF};
  localparam logic [W-1:0] V_IDX [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0023,
      32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0010, 32'h0000_0003, 32'h0, 32'h1, 32'h0};
  localparam logic [W-1:0] V_CST [NV] = '{32'h0, 32'hDEAD_BEEF, 32'hFFFF_FFF0, 32'h0,
      32'h0, 32'h0000_4444, 32'h0, 32'h0, 32'h0, 32'h0000_0008, 32'h0000_0040,
      32'h0000_0099, 32'h0000_0001, 32'h0};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [3:0]   req_mode = '0;
  logic [1:0]   req_size = '0;
  logic [W-1:0] req_base = '0;
  logic [W-1:0] req_index = '0;
  logic [W-1:0] req_const = '0;
  logic         rd_en;
  logic [W-1:0] rd_addr;
  logic [W-1:0] rd_data = '0;
  logic         wb_en;
  logic [W-1:0] wb_data;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [W-1:0] rsp_data;
  logic         rsp_illegal;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  opnd_addr_unit #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_size(req_size), .req_base(req_base),
    .req_index(req_index), .req_const(req_const), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wb_en(wb_en), .wb_data(wb_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_illegal(rsp_illegal)
  );

  function automatic logic [W-1:0] memval(input logic [W-1:0] a);
    return {a[15:0] ^ 16'hA5A5, a[15:0] + 16'h0100};
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= memval(rd_addr);

  // Port monitor, cleared on the accepting edge.
  logic         mon_clr = 1'b0;
  int           ecnt, rd_cnt, wb_cnt, rd_c0, rd_c1, wb_c;
  logic [W-1:0] rd_a0, rd_a1, wb_d;

  always @(posedge clk) begin
    if (mon_clr) begin
      ecnt <= 0; rd_cnt <= 0; wb_cnt <= 0;
    end else begin
      ecnt <= ecnt + 1;
      if (rd_en) begin
        if (rd_cnt == 0) begin rd_a0 <= rd_addr; rd_c0 <= ecnt; end
        else begin rd_a1 <= rd_addr; rd_c1 <= ecnt; end
        rd_cnt <= rd_cnt + 1;
      end
      if (wb_en) begin wb_d <= wb_data; wb_c <= ecnt; wb_cnt <= wb_cnt + 1; end
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string mtag(input logic [3:0] m);
    case (m)
      4'd0, 4'd1:             return "R3";
      4'd2, 4'd3, 4'd4, 4'd5: return "R4";
      4'd6:                   return "R5";
      4'd7:                   return "R6";
      4'd8:                   return "R7";
      4'd9:                   return "R8 R9";
      default:                return "R10";
    endcase
  endfunction

  function automatic logic [W-1:0] exp_addr(input logic [3:0] m, input logic [1:0] s,
      input logic [W-1:0] b, input logic [W-1:0] x, input logic [W-1:0] c);
    logic [W-1:0] d;
    d = W'(1) << s;
    case (m)
      4'd2:    return c + b;
      4'd4:    return b + x;
      4'd5:    return c;
      4'd8:    return b - d;
      4'd9:    return c + b + x * d;
      default: return b;
    endcase
  endfunction

  int lat;

  task automatic issue(input logic [3:0] m, input logic [1:0] s,
      input logic [W-1:0] b, input logic [W-1:0] x, input logic [W-1:0] c, input bit rdy);
    @(negedge clk);
    req_mode = m; req_size = s; req_base = b; req_index = x; req_const = c;
    req_valid = 1'b1; mon_clr = 1'b1; rsp_ready = rdy;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; mon_clr = 1'b0; lat = 0;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    #3;
    // R1 reset state
    chk("R1 req_ready", W'(req_ready), 1);
    chk("R1 rsp_valid", W'(rsp_valid), 0);
    chk("R1 rd_en", W'(rd_en), 0);
    chk("R1 wb_en", W'(wb_en), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [3:0]   m;
      logic [W-1:0] a0, edat, d;
      int           nrd, nwb, elat;
      bit           ill;
      m   = V_MODE[i];
      ill = (m > 4'd9);
      d   = W'(1) << V_SIZE[i];
      a0  = exp_addr(m, V_SIZE[i], V_BASE[i], V_IDX[i], V_CST[i]);
      nrd = (m == 4'd0 || m == 4'd1 || ill) ? 0 : (m == 4'd6 ? 2 : 1);
      nwb = (m == 4'd7 || m == 4'd8) ? 1 : 0;
      elat = (nrd == 0) ? 0 : nrd + 1;
      if (ill)            edat = '0;
      else if (m == 4'd0) edat = V_BASE[i];
      else if (m == 4'd1) edat = V_CST[i];
      else if (m == 4'd6) edat = memval(memval(V_BASE[i]));
      else                edat = memval(a0);
      issue(m, V_SIZE[i], V_BASE[i], V_IDX[i], V_CST[i], 1'b1);
      chk({mtag(m), " rsp_valid"}, W'(rsp_valid), 1);
      chk({mtag(m), " rsp_data"}, rsp_data, edat);
      chk({mtag(m), " R10 rsp_illegal"}, W'(rsp_illegal), W'(ill));
      chk({mtag(m), " latency"}, W'(lat), W'(elat));
      chk({mtag(m), " read count"}, W'(rd_cnt), W'(nrd));
      if (nrd > 0) chk({mtag(m), " first read addr"}, rd_a0, a0);
      if (m == 4'd6) begin
        chk("R5 second read addr", rd_a1, memval(V_BASE[i]));
        chk("R5 second read cycle", W'(rd_c1), W'(rd_c0 + 1));
      end
      chk({mtag(m), " R11 wb count"}, W'(wb_cnt), W'(nwb));
      if (m == 4'd7) begin
        chk("R6 R9 wb data", wb_d, V_BASE[i] + d);
        chk("R6 wb after read", W'(wb_c), W'(rd_c0 + 1));
      end
      if (m == 4'd8) begin
        chk("R7 R9 wb data", wb_d, V_BASE[i] - d);
        chk("R7 wb with read", W'(wb_c), W'(rd_c0));
      end
      @(posedge clk);
      @(negedge clk);
      chk("R2 response taken", W'({rsp_valid, req_ready}), W'(2'b01));
    end

    // R2 back-pressure: response held while rsp_ready is low
    begin
      logic [W-1:0] held;
      issue(4'd3, 2'd0, 32'h0000_0ABC, 32'h0, 32'h0, 1'b0);
      held = rsp_data;
      chk("R2 held data value", held, memval(32'h0000_0ABC));
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk("R2 rsp_valid held", W'(rsp_valid), 1);
        chk("R2 rsp_data stable", rsp_data, held);
        chk("R2 req_ready low while busy", W'(req_ready), 0);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      chk("R2 released", W'({rsp_valid, req_ready}), W'(2'b01));
    end

    // R1 reset in the middle of a memory-indirect operation
    @(negedge clk);
    req_mode = 4'd6; req_base = 32'h40; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 mid-op req_ready", W'(req_ready), 1);
    chk("R1 mid-op rsp_valid", W'(rsp_valid), 0);
    chk("R1 mid-op rd_en", W'(rd_en), 0);
    chk("R1 mid-op wb_en", W'(wb_en), 0);
    @(negedge clk);
    rst_n = 1'b1;
    issue(4'd0, 2'd0, 32'h0BAD_F00D, 32'h0, 32'h0, 1'b1);
    chk("R1 R3 after reset", rsp_data, 32'h0BAD_F00D);
    @(posedge clk);
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=%0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule